// File: doc/BRIEF.md
# Asynchronous Host Write Capture

This block takes register writes from an external processor bus whose clock never reaches the logic. The host drives an active-low write strobe together with an address and a data word. All three are asynchronous to the local system clock, which runs at least fast enough that every host bus cycle spans two or more of its rising edges. The strobe is brought into the system clock domain through a short flip-flop chain. A falling-edge detector on the synchronized strobe then marks each new host write once, no matter how long the strobe stays low.

The raw first sample of the strobe may land on either side of an edge, or may go metastable. The write therefore waits one further system clock. During that wait the address is predecoded into a one-hot set of write enables, one per register. On the following edge the data bus is loaded straight into the selected register. The host holds address and data stable for the whole strobe period, so neither bus needs a capture register of its own. Reads bypass this path entirely: a separate read address selects a register combinationally.

The host bus cannot be stalled, so the interface has no valid/ready handshake and no back-pressure. The strobe is the only qualifier, and the timing contract on the host takes the place of flow control.

Top module: `hostwr_capture`

## Requirements
- R1: A synchronous active-high reset clears every register to zero. During reset and on the cycle after it, no register is written.
- R2: When the write strobe is first sampled low at rising edge k, after being sampled high at edge k-1, the addressed register takes the data bus value at edge k+3. The read port still shows the old value after edge k+2.
- R3: A strobe held low for many system clocks causes exactly one write. Changing the data bus after the commit edge, while the strobe is still low, leaves the register unchanged.
- R4: A write changes only the register selected by the 3-bit address (one-hot enable, register index = address value). All other registers keep their contents.
- R5: A strobe that is already low when reset ends causes no write. It must go high and then low again to write.
- R6: The read data port shows the register selected by the read address combinationally, without waiting for a clock edge.
- R7: A strobe that returns high for at least two system clocks before falling again produces a second, separate write.
- R8: All eight addresses, including 0 and 7, are writable with full 16-bit data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| host_addr | input | 3 | Host register address, asynchronous |
| host_data | input | 16 | Host write data, asynchronous |
| rd_addr | input | 3 | Read select, system clock domain |
| rd_data | output | 16 | Selected register contents (combinational) |

## Verification
The assertions assume that the host keeps the strobe low for at least two system clocks. They also assume the strobe stays high for at least two clocks between writes, and that address and data do not move from the falling strobe until three edges after it is first sampled low. Under those conditions each enable pulse can be traced back to a high-then-low strobe history and to the address seen one edge earlier. The stimulus changes every host pin only at falling clock edges, so samples are never ambiguous. It holds address and data through the commit edge, and it never spaces strobes closer than the stated minimum. Metastability itself is therefore not exercised; only the edge bookkeeping around it is.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
  localparam int HWC_ADDR_W      = 3;
  localparam int HWC_DATA_W      = 16;
  localparam int HWC_SYNC_STAGES = 2;
endpackage

// File: rtl/hwc_sync.sv
module hwc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= 1'b0;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/hwc_wr_decode.sv
module hwc_wr_decode #(
  parameter int ADDR_W = 3,
  localparam int NREGS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_s,
  input  logic [ADDR_W-1:0] addr,
  output logic [NREGS-1:0]  we
);
  logic strobe_prev_q;
  logic fall;
  logic [NREGS-1:0] we_d;

  always_ff @(posedge clk) begin
    if (rst) strobe_prev_q <= 1'b0;
    else     strobe_prev_q <= strobe_s;
  end

  assign fall = strobe_prev_q & ~strobe_s;

  genvar i;
  generate
    for (i = 0; i < NREGS; i++) begin : g_dec
      assign we_d[i] = fall && (addr == ADDR_W'(i));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) we <= '0;
    else     we <= we_d;
  end
endmodule

// File: rtl/hwc_regfile.sv
module hwc_regfile #(
  parameter int NREGS  = 8,
  parameter int DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NREGS-1:0]              we,
  input  logic [DATA_W-1:0]             wdata,
  output logic [NREGS-1:0][DATA_W-1:0]  regs
);
  genvar i;
  generate
    for (i = 0; i < NREGS; i++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)        regs[i] <= '0;
        else if (we[i]) regs[i] <= wdata;
      end
    end
  endgenerate
endmodule

// File: rtl/hostwr_capture.sv
module hostwr_capture #(
  parameter int ADDR_W      = hwc_pkg::HWC_ADDR_W,
  parameter int DATA_W      = hwc_pkg::HWC_DATA_W,
  parameter int SYNC_STAGES = hwc_pkg::HWC_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int NREGS = 1 << ADDR_W;

  logic                         wr_sync;
  logic [NREGS-1:0]             we_q;
  logic [NREGS-1:0][DATA_W-1:0] regs;

  hwc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(host_wr_n), .sync_out(wr_sync)
  );

  hwc_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst(rst), .strobe_s(wr_sync), .addr(host_addr), .we(we_q)
  );

  hwc_regfile #(.NREGS(NREGS), .DATA_W(DATA_W)) u_rf (
    .clk(clk), .rst(rst), .we(we_q), .wdata(host_data), .regs(regs)
  );

  assign rd_data = regs[rd_addr];
endmodule

// File: rtl/hwc_checker.sv
module hwc_checker #(
  parameter int ADDR_W = 3,
  localparam int NREGS = 1 << ADDR_W
) (
  input logic              clk,
  input logic              rst,
  input logic              host_wr_n,
  input logic [ADDR_W-1:0] host_addr,
  input logic [NREGS-1:0]  we
);
  AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(we)); // R4

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (we != '0) |=> (we == '0)); // R3

  AST_WE_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
    (we != '0) |-> ($past(host_wr_n, 3) == 1'b0 && $past(host_wr_n, 4) == 1'b1)); // R2

  AST_WE_ADDR_MATCH: assert property (@(posedge clk) disable iff (rst)
    (we != '0) |-> (we == (NREGS'(1) << $past(host_addr)))); // R4

  AST_NO_WE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (we == '0)); // R1
endmodule

bind hostwr_capture hwc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .host_wr_n(host_wr_n), .host_addr(host_addr), .we(we_q)
);

// File: tb/hostwr_capture_tb_top.sv
module hostwr_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr_n = 1'b1;
  logic [2:0]  host_addr = '0;
  logic [15:0] host_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hostwr_capture dut_i (
    .clk(clk), .rst(rst), .host_wr_n(host_wr_n), .host_addr(host_addr),
    .host_data(host_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // Behavioural reference: countdown from first low sample to commit
  logic [15:0] mreg [8];
  int          cd = 0;
  logic [2:0]  cap_a = '0;
  logic        prev_s = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 8; i++) mreg[i] = '0;
      cd = 0;
      prev_s = 1'b0;
    end else begin
      if (cd == 1) begin mreg[cap_a] = host_data; cd = 0; end
      else if (cd == 2) begin cap_a = host_addr; cd = 1; end
      else if (cd == 3) cd = 2;
      if (prev_s && !host_wr_n) cd = 3;
      prev_s = host_wr_n;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #5;
    if (!rst && !done) chk(rd_data === mreg[rd_addr], "R2 model", rd_data, mreg[rd_addr]);
  end

  task automatic host_write(input logic [2:0] a, input logic [15:0] d, input int low);
    @(negedge clk);
    host_addr = a; host_data = d; host_wr_n = 1'b0;
    repeat (low) @(negedge clk);
    host_wr_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic read_chk(input logic [2:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    rd_addr = a;
    #2;
    chk(rd_data === exp, req, rd_data, exp);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R1: all cleared
    for (int i = 0; i < 8; i++) read_chk(3'(i), 16'h0000, "R1 reset value");

    // R8 / R4: boundary addresses
    host_write(3'd0, 16'h1234, 2);
    host_write(3'd7, 16'hBEEF, 2);
    read_chk(3'd0, 16'h1234, "R8 addr0");
    read_chk(3'd7, 16'hBEEF, "R8 addr7");
    for (int i = 1; i < 7; i++) read_chk(3'(i), 16'h0000, "R4 untouched");

    // R2: commit edge timing, drop at negedge -> first low sample at edge k
    @(negedge clk);
    rd_addr = 3'd5; host_addr = 3'd5; host_data = 16'hA5A5; host_wr_n = 1'b0;
    @(negedge clk); // after k
    @(negedge clk); // after k+1
    host_wr_n = 1'b1;
    @(negedge clk); // after k+2
    #2 chk(rd_data === 16'h0000, "R2 not before k+3", rd_data, 16'h0000);
    @(negedge clk); // after k+3
    #2 chk(rd_data === 16'hA5A5, "R2 at k+3", rd_data, 16'hA5A5);
    repeat (2) @(negedge clk);

    // R3: long strobe, data changed after commit
    @(negedge clk);
    host_addr = 3'd3; host_data = 16'h1111; host_wr_n = 1'b0;
    repeat (5) @(negedge clk);
    host_data = 16'h2222;
    repeat (5) @(negedge clk);
    host_wr_n = 1'b1;
    repeat (3) @(negedge clk);
    read_chk(3'd3, 16'h1111, "R3 single write");

    // R7: second write after two high clocks
    @(negedge clk);
    host_addr = 3'd2; host_data = 16'h0AAA; host_wr_n = 1'b0;
    repeat (2) @(negedge clk);
    host_wr_n = 1'b1;
    repeat (2) @(negedge clk);
    host_data = 16'h0BBB; host_wr_n = 1'b0;
    repeat (2) @(negedge clk);
    host_wr_n = 1'b1;
    repeat (3) @(negedge clk);
    read_chk(3'd2, 16'h0BBB, "R7 second write");

    // R6: combinational read, no clock edge between select and check
    @(negedge clk);
    rd_addr = 3'd7; #1 chk(rd_data === 16'hBEEF, "R6 comb read", rd_data, 16'hBEEF);
    rd_addr = 3'd0; #1 chk(rd_data === 16'h1234, "R6 comb read", rd_data, 16'h1234);

    // R5: strobe low across reset release
    @(negedge clk);
    rst = 1'b1; host_addr = 3'd6; host_data = 16'h6666; host_wr_n = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    read_chk(3'd6, 16'h0000, "R5 no write from held strobe");
    read_chk(3'd0, 16'h0000, "R1 cleared by second reset");
    host_wr_n = 1'b1;
    repeat (3) @(negedge clk);
    host_write(3'd6, 16'h7777, 3);
    read_chk(3'd6, 16'h7777, "R5 write after re-arm");
    for (int i = 0; i < 6; i++) read_chk(3'(i), 16'h0000, "R4 untouched after R5");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R2 actual=%h expected=%h", 16'h0, 16'h1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule